// File: doc/BRIEF.md
# Square-Wave Tick and Refresh Strobe Timer Pair

This block holds two fixed-purpose 16-bit down-counters that run from one shared timer clock enable. That enable pulses once per timer period of about 838 ns, which is a 14.31818 MHz rate divided down from the system clock. Counter 0 drives a square-wave system tick interrupt level. Counter 1 drives a refresh-request level that drops for one timer period in every count cycle. Neither counter's mode can be changed.

Software sends an initial count to either counter over a single-cycle write port. The counter does not start on the write. It loads the value on the first timer tick after the write and then runs on its own, reloading at every terminal count. A value written while the counter is already running waits in a holding register and is used at that counter's next reload.

Top module: `sys_interval_timer`

## Requirements
- R1: After reset both outputs are high and both counters are idle. Ticks that arrive before any count has been written do not change either output.
- R2: A count written with `wr_en` high in a given cycle is loaded on the first `tick_en` cycle that comes strictly after that cycle. If a second write reaches an idle counter before that load, the second value replaces the first. The load tick itself leaves the output high.
- R3: Counter 0 (`wr_sel` = 0) starts with `tick_irq_o` high. For an even count N, the output inverts after every N/2 ticks that follow the load tick, so the square wave has a period of N ticks.
- R4: When counter 0 is given an odd count N of 3 or more, it uses N-1. The output then inverts every (N-1)/2 ticks.
- R5: For either counter, a written count of 0 or 1 means 65536. Counter 0 then inverts every 32768 ticks, and counter 1 has a period of 65536 ticks.
- R6: Counter 1 (`wr_sel` = 1) starts with `refresh_req_o` high. For a count N, the output goes low on the (N-1)th tick after the load and returns high on the Nth tick. The count then restarts from the initial value, so the period is N ticks.
- R7: A write to a counter that is running does not disturb its current count cycle. The new value is used from that counter's next reload point onward.
- R8: Both outputs change only on cycles where `tick_en` is high.
- R9: A write affects only the counter chosen by `wr_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer period enable, one clock wide |
| wr_en | input | 1 | Count write strobe |
| wr_sel | input | 1 | Target counter: 0 = square wave, 1 = refresh |
| wr_data | input | 16 | Initial count value |
| tick_irq_o | output | 1 | Square-wave system tick interrupt level |
| refresh_req_o | output | 1 | Refresh request level, low for one tick per period |

## Verification
The hardest case to reach is a write that lands on a running counter in the same cycle as that counter's reload, or in the same cycle as the deferred-load tick of an idle counter. To reach it, the stimulus uses very small counts together with dense random ticks and writes, so these coincidences happen often. The 65536 interpretation of 0 and 1 is reached only through long directed runs with the tick held high, during which the bench watches the exact tick on which each output edge occurs.

// File: rtl/timer_pkg.sv
// Shared constants for the interval timer pair.
// Assumes a single clock domain; the tick rate is set by the enclosing system.
package timer_pkg;
    localparam int CNT_W   = 16;
    localparam int NUM_CNT = 2;
endpackage

// File: rtl/count_capture.sv
// Holds the software-written initial count of one counter and the deferred-load
// request for it. Assumes wr_hit is a single-cycle strobe. A write to an idle
// counter arms a load for the next tick. A write to a running counter only
// replaces the reload value.
module count_capture #(
    parameter int CNT_W = timer_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick_en,
    input  logic             running,
    output logic [CNT_W-1:0] init_q,
    output logic             load_o
);
    logic pend_q;

    // Keep the most recent written count for loads and reloads.
    always_ff @(posedge clk) begin
        if (!rst_n)      init_q <= '0;
        else if (wr_hit) init_q <= wr_data;
    end

    // Arm the deferred load on an idle write and clear it when the load happens.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pend_q <= 1'b0;
        else if (wr_hit && !running)  pend_q <= 1'b1;
        else if (tick_en)             pend_q <= 1'b0;
    end

    assign load_o = pend_q && tick_en;

    // R2: a write to an idle counter always leaves a load pending.
    p_idle_write_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !running) |=> pend_q);
    // R7: a write to a running counter never arms a load by itself.
    p_run_write_no_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && running && !pend_q) |=> !pend_q);
endmodule

// File: rtl/square_wave_core.sv
// Counter 0: square-wave generator. Assumes the count value is taken from
// count_capture. The count steps down by two on each tick. When it reaches
// zero, the output inverts and the even-rounded initial count is reloaded.
// Counts of 0 and 1 mean 65536.
module square_wave_core #(
    parameter int CNT_W = timer_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] init,
    output logic             running,
    output logic             wave_o
);
    localparam int FULL_W = CNT_W + 1;
    localparam logic [FULL_W-1:0] WRAP = FULL_W'(1) << CNT_W;

    logic [FULL_W-1:0] cnt_q;
    logic [FULL_W-1:0] even_init;

    // Round the count down to an even value and map zero to the full range.
    always_comb begin
        even_init = {1'b0, init[CNT_W-1:1], 1'b0};
        if (even_init == '0) even_init = WRAP;
    end

    // Step by two on each tick; invert the output and reload at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            running <= 1'b0;
            wave_o  <= 1'b1;
        end else if (tick_en) begin
            if (load) begin
                cnt_q   <= even_init;
                running <= 1'b1;
                wave_o  <= 1'b1;
            end else if (running) begin
                if (cnt_q == FULL_W'(2)) begin
                    cnt_q  <= even_init;
                    wave_o <= ~wave_o;
                end else begin
                    cnt_q <= cnt_q - FULL_W'(2);
                end
            end
        end
    end

    // R4: the running count is always even.
    p_even_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !cnt_q[0]);
    // R8: without a tick the output holds.
    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(wave_o));
    // R1: an idle counter keeps its output high.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> wave_o);
    // R2: the load tick leaves the output high.
    p_load_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && tick_en) |=> (wave_o && running));
endmodule

// File: rtl/rate_gen_core.sv
// Counter 1: rate generator. Assumes the count value is taken from
// count_capture. The count steps down by one on each tick. The output is low
// while the count is 1 and is restored on the following reload. Counts of 0
// and 1 mean 65536.
module rate_gen_core #(
    parameter int CNT_W = timer_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] init,
    output logic             running,
    output logic             strobe_o
);
    localparam int FULL_W = CNT_W + 1;
    localparam logic [FULL_W-1:0] WRAP = FULL_W'(1) << CNT_W;

    logic [FULL_W-1:0] cnt_q;
    logic [FULL_W-1:0] full_init;

    // Map the degenerate counts 0 and 1 to the full range.
    always_comb begin
        full_init = {1'b0, init};
        if (init < CNT_W'(2)) full_init = WRAP;
    end

    // Step down by one; drop the output at count 1 and reload after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            running  <= 1'b0;
            strobe_o <= 1'b1;
        end else if (tick_en) begin
            if (load) begin
                cnt_q    <= full_init;
                running  <= 1'b1;
                strobe_o <= 1'b1;
            end else if (running) begin
                if (cnt_q == FULL_W'(1)) begin
                    cnt_q    <= full_init;
                    strobe_o <= 1'b1;
                end else begin
                    cnt_q    <= cnt_q - FULL_W'(1);
                    strobe_o <= (cnt_q != FULL_W'(2));
                end
            end
        end
    end

    // R6: a low output lasts exactly one tick.
    p_one_tick_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_o && tick_en) |=> strobe_o);
    // R8: without a tick the output holds.
    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(strobe_o));
    // R1: an idle counter keeps its output high.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> strobe_o);
endmodule

// File: rtl/sys_interval_timer.sv
// Top of the fixed-function timer pair. It routes count writes to two capture
// stages and feeds a square-wave core (counter 0) and a rate-generator core
// (counter 1). Assumes tick_en is a one-cycle pulse at the timer rate.
module sys_interval_timer
    import timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             tick_irq_o,
    output logic             refresh_req_o
);
    logic [CNT_W-1:0] init_w [NUM_CNT];
    logic             load_w [NUM_CNT];
    logic             run_w  [NUM_CNT];

    // One capture stage per counter, chosen by the select bit.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cap
        count_capture #(.CNT_W(CNT_W)) cap_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_en && (wr_sel == 1'(g))),
            .wr_data (wr_data),
            .tick_en (tick_en),
            .running (run_w[g]),
            .init_q  (init_w[g]),
            .load_o  (load_w[g])
        );
    end

    square_wave_core #(.CNT_W(CNT_W)) sq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .load    (load_w[0]),
        .init    (init_w[0]),
        .running (run_w[0]),
        .wave_o  (tick_irq_o)
    );

    rate_gen_core #(.CNT_W(CNT_W)) rg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (load_w[1]),
        .init     (init_w[1]),
        .running  (run_w[1]),
        .strobe_o (refresh_req_o)
    );

    // R9: a write to counter 1 leaves counter 0's output unchanged without a tick.
    p_sel_isolation_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && !tick_en) |=> $stable(tick_irq_o));
endmodule

// File: tb/sys_interval_timer_tb_top.sv
// Self-checking bench with a behavioural model built from the requirements.
module sys_interval_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        tick_irq_o, refresh_req_o;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    int m_init [2];
    bit m_pend [2];
    bit m_run  [2];
    bit m_out  [2];
    int m_rem  [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    sys_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data),
        .tick_irq_o(tick_irq_o), .refresh_req_o(refresh_req_o)
    );

    function automatic int half0(int n);
        return (n < 2) ? 32768 : (n >> 1);
    endfunction

    function automatic int per1(int n);
        return (n < 2) ? 65536 : n;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_init[i] = 0; m_pend[i] = 0; m_run[i] = 0; m_out[i] = 1; m_rem[i] = 0;
        end
    endtask

    task automatic model_edge(bit tk, bit wr, bit sel, int d);
        for (int i = 0; i < 2; i++) begin
            bit pre_run = m_run[i];
            if (tk) begin
                if (m_pend[i]) begin
                    m_pend[i] = 0; m_run[i] = 1; m_out[i] = 1;
                    m_rem[i] = (i == 0) ? half0(m_init[i]) : per1(m_init[i]);
                end else if (m_run[i]) begin
                    m_rem[i]--;
                    if (i == 0) begin
                        if (m_rem[i] == 0) begin
                            m_out[i] = !m_out[i];
                            m_rem[i] = half0(m_init[i]);
                        end
                    end else begin
                        if (m_rem[i] == 1) m_out[i] = 0;
                        else if (m_rem[i] == 0) begin
                            m_out[i] = 1;
                            m_rem[i] = per1(m_init[i]);
                        end
                    end
                end
            end
            if (wr && (sel == i[0])) begin
                m_init[i] = d;
                if (!pre_run) m_pend[i] = 1;
            end
        end
    endtask

    task automatic check_outs();
        n_checks++;
        if (tick_irq_o !== m_out[0] || refresh_req_o !== m_out[1]) begin
            n_errors++;
            $display("FAIL %s cycle %0d: irq=%0b refresh=%0b expected irq=%0b refresh=%0b",
                     cur_req, cycles, tick_irq_o, refresh_req_o, m_out[0], m_out[1]);
        end
    endtask

    // Drive one cycle at the falling edge, then compare after the rising edge.
    task automatic step(bit tk, bit wr, bit sel, int d);
        @(negedge clk);
        tick_en = tk; wr_en = wr; wr_sel = sel; wr_data = 16'(d);
        @(posedge clk);
        model_edge(tk, wr, sel, d);
        #1;
        check_outs();
        cycles++;
    endtask

    task automatic run_ticks(int n);
        for (int k = 0; k < n; k++) step(1, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs high after reset and unaffected by ticks while idle.
        cur_req = "R1";
        run_ticks(20);
        // R2/R3: deferred load, even count 6 on counter 0; write coincides with a tick.
        cur_req = "R2";
        step(1, 1, 0, 6);
        step(0, 0, 0, 0);
        cur_req = "R3";
        run_ticks(14);
        // R6: counter 1 count 5, low pulse on 4th tick after load.
        cur_req = "R6";
        step(0, 1, 1, 5);
        run_ticks(16);
        // R4: odd count reaches a running counter and is used at the next reload.
        cur_req = "R4";
        step(0, 1, 0, 9);
        run_ticks(30);
        // R7: new count written mid-cycle on counter 1 takes effect at reload.
        cur_req = "R7";
        step(1, 1, 1, 3);
        run_ticks(20);
        // R8/R9: random ticks and writes with small counts.
        cur_req = "R8/R9";
        for (int k = 0; k < 20000; k++) begin
            bit tk  = ($urandom_range(0, 99) < 50);
            bit wr  = ($urandom_range(0, 99) < 4);
            bit sel = 1'($urandom_range(0, 1));
            int d   = $urandom_range(0, 12);
            step(tk, wr, sel, d);
        end
        // R5: counts 0 and 1 mean 65536 (fresh reset to make both idle).
        cur_req = "R5";
        @(negedge clk); rst_n = 1'b0; tick_en = 0; wr_en = 0;
        @(posedge clk); #1; model_reset();
        @(negedge clk); rst_n = 1'b1;
        step(0, 1, 0, 1);
        step(0, 1, 1, 0);
        run_ticks(65540);
        if (cycles > WATCHDOG) begin
            n_errors++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
        end
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * (WATCHDOG + 1000));
        n_errors++;
        $display("FAIL watchdog: run hung at cycle %0d expected completion", cycles);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule